// File: doc/BRIEF.md
# Ping-Pong Packet Receive Buffer

This block receives packets for one bulk-out style endpoint into two packet buffers that take turns. The link side pushes bytes one per cycle and marks the end of each packet with a strobe. The CPU side reads the oldest committed packet byte by byte. It sees that packet's byte count and a data-ready flag. When the CPU has finished with a packet, it writes 1 to a one-shot release control. That frees the buffer it just read, so the next incoming packet can land there.

Each buffer keeps its own byte count and its own read pointer. Once a packet is committed, its count is frozen until the CPU releases it. While both buffers hold unread packets, the link side is told not-ready and nothing it sends is stored. A sticky flag records that a packet longer than one buffer arrived.

Top module: `pingpong_rx_fifo`

## Requirements
- R1: After reset, `cpu_count_o` is 0, `cpu_ready_o` is 0, `lnk_nak_o` is 0 and `lnk_ovf_o` is 0.
- R2: Each cycle with `lnk_valid_i` high stores one byte into the buffer being filled. A cycle with `lnk_eop_i` high commits that packet. From the next cycle on, `cpu_ready_o` is 1, `cpu_count_o` equals the number of stored bytes, and `cpu_data_o` presents the bytes in arrival order, advancing by one on each cycle with `cpu_rd_i` high.
- R3: `cpu_count_o` reads 0 while `cpu_ready_o` is 0, so a packet still being received is not visible. While a packet is presented and not released, its count does not change, even as link bytes fill the other buffer.
- R4: A cycle with `cpu_trg_we_i` high and `cpu_trg_bit_i` high releases the presented buffer, clearing its count and read pointer. A cycle with `cpu_trg_we_i` high and `cpu_trg_bit_i` low has no effect.
- R5: A release written while no packet is presented (`cpu_ready_o` 0) is ignored and changes no output.
- R6: When both buffers hold unread packets, `lnk_nak_o` is 1, and link bytes and end-of-packet strobes are dropped.
- R7: A buffer holds at most DEPTH (default 64) bytes. Bytes beyond that are dropped, and `lnk_ovf_o` is set and stays set until reset.
- R8: Packets are presented in commit order. On release, if the other buffer holds a packet it is presented at once. Otherwise `cpu_ready_o` falls until the next commit.
- R9: An end-of-packet strobe with no bytes before it commits a zero-length packet: `cpu_ready_o` is 1 and `cpu_count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lnk_valid_i | input | 1 | Link byte valid |
| lnk_data_i | input | DATA_W | Link byte |
| lnk_eop_i | input | 1 | Link end-of-packet strobe |
| lnk_nak_o | output | 1 | No free buffer; link input is dropped |
| lnk_ovf_o | output | 1 | Sticky packet overflow |
| cpu_rd_i | input | 1 | Advance the CPU read pointer by one byte |
| cpu_data_o | output | DATA_W | Byte at the CPU read pointer |
| cpu_count_o | output | CNT_W | Byte count of the presented packet |
| cpu_ready_o | output | 1 | A committed packet is presented |
| cpu_trg_we_i | input | 1 | Write strobe for the release control |
| cpu_trg_bit_i | input | 1 | Release control value; 1 releases |

## Verification
Every cycle, the assertions check these properties:
- the presented count stays stable until a release;
- both buffers being full always raises not-ready;
- overflow is sticky;
- the count never exceeds the buffer depth;
- a release while both buffers are full keeps data ready;
- a release written as 0, or written while nothing is presented, does not change readiness.

Only the bench scenarios can show the rest:
- byte contents and their order;
- the hand-over from one buffer to the other in commit order;
- the read pointer restarting at zero when a buffer is reused;
- dropped link input during not-ready;
- truncation of an oversized packet;
- the zero-length packet.

// File: rtl/pprx_pkg.sv
package pprx_pkg;
  typedef logic side_t;

  function automatic side_t other_side(side_t s);
    return ~s;
  endfunction
endpackage

// File: rtl/pprx_bank.sv
module pprx_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              release_i,
  input  logic              rd_en_i,
  output logic              full_o,
  output logic              cap_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, ptr_q;
  logic              full_q;

  assign cap_o     = (cnt_q == CNT_W'(DEPTH));
  assign full_o    = full_q;
  assign cnt_o     = cnt_q;
  assign rd_data_o = mem_q[ptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !full_q && !cap_o) mem_q[cnt_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else if (release_i) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else begin
      if (commit_i) full_q <= 1'b1;
      if (wr_en_i && !full_q && !cap_o) cnt_q <= cnt_q + CNT_W'(1);
      if (rd_en_i && full_q && (ptr_q < cnt_q)) ptr_q <= ptr_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pprx_ctrl.sv
module pprx_ctrl
  import pprx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lnk_valid_i,
  input  logic       lnk_eop_i,
  input  logic       trg_we_i,
  input  logic       trg_bit_i,
  input  logic [1:0] full_i,
  input  logic [1:0] cap_i,
  output logic [1:0] wr_en_o,
  output logic [1:0] commit_o,
  output logic [1:0] release_o,
  output side_t      cpu_sel_o,
  output logic       nak_o,
  output logic       ovf_o
);
  side_t fill_q, cpu_q, cpu_d;
  logic  accept, commit, rel, ovf_q;

  assign nak_o  = full_i[fill_q];
  assign accept = lnk_valid_i && !nak_o;
  assign commit = lnk_eop_i && !nak_o;
  assign rel    = trg_we_i && trg_bit_i && full_i[cpu_q];

  always_comb begin
    wr_en_o   = '0;
    commit_o  = '0;
    release_o = '0;
    wr_en_o[fill_q]  = accept && !cap_i[fill_q];
    commit_o[fill_q] = commit;
    release_o[cpu_q] = rel;
  end

  // presented side: oldest full buffer
  always_comb begin
    cpu_d = cpu_q;
    if (rel) begin
      if (full_i[other_side(cpu_q)]) cpu_d = other_side(cpu_q);
      else if (commit)               cpu_d = fill_q;
    end else if (!full_i[cpu_q] && commit) begin
      cpu_d = fill_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= 1'b0;
      cpu_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cpu_q <= cpu_d;
      if (commit) fill_q <= other_side(fill_q);
      if (accept && cap_i[fill_q]) ovf_q <= 1'b1;
    end
  end

  assign cpu_sel_o = cpu_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/pingpong_rx_fifo.sv
module pingpong_rx_fifo
  import pprx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lnk_valid_i,
  input  logic [DATA_W-1:0] lnk_data_i,
  input  logic              lnk_eop_i,
  output logic              lnk_nak_o,
  output logic              lnk_ovf_o,
  input  logic              cpu_rd_i,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic [CNT_W-1:0]  cpu_count_o,
  output logic              cpu_ready_o,
  input  logic              cpu_trg_we_i,
  input  logic              cpu_trg_bit_i
);
  localparam int NBANK = 2;

  logic [NBANK-1:0]  bank_full, bank_cap, bank_wr, bank_commit, bank_rel;
  logic [CNT_W-1:0]  bank_cnt  [NBANK];
  logic [DATA_W-1:0] bank_data [NBANK];
  side_t             cpu_sel;

  pprx_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lnk_valid_i (lnk_valid_i),
    .lnk_eop_i   (lnk_eop_i),
    .trg_we_i    (cpu_trg_we_i),
    .trg_bit_i   (cpu_trg_bit_i),
    .full_i      (bank_full),
    .cap_i       (bank_cap),
    .wr_en_o     (bank_wr),
    .commit_o    (bank_commit),
    .release_o   (bank_rel),
    .cpu_sel_o   (cpu_sel),
    .nak_o       (lnk_nak_o),
    .ovf_o       (lnk_ovf_o)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    pprx_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (bank_wr[g]),
      .wr_data_i (lnk_data_i),
      .commit_i  (bank_commit[g]),
      .release_i (bank_rel[g]),
      .rd_en_i   (cpu_rd_i && (cpu_sel == side_t'(g))),
      .full_o    (bank_full[g]),
      .cap_o     (bank_cap[g]),
      .cnt_o     (bank_cnt[g]),
      .rd_data_o (bank_data[g])
    );
  end

  assign cpu_ready_o = bank_full[cpu_sel];
  assign cpu_count_o = cpu_ready_o ? bank_cnt[cpu_sel] : '0;
  assign cpu_data_o  = bank_data[cpu_sel];
endmodule

// File: rtl/pingpong_rx_fifo_chk.sv
module pingpong_rx_fifo_chk #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lnk_eop_i,
  input logic             lnk_nak_o,
  input logic             lnk_ovf_o,
  input logic [CNT_W-1:0] cpu_count_o,
  input logic             cpu_ready_o,
  input logic             cpu_trg_we_i,
  input logic             cpu_trg_bit_i,
  input logic [1:0]       full_i
);
  AST_COUNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && !(cpu_trg_we_i && cpu_trg_bit_i) |=> $stable(cpu_count_o)); // R3
  AST_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_trg_we_i && !cpu_trg_bit_i && cpu_ready_o |=> cpu_ready_o); // R4
  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_trg_we_i && !cpu_ready_o && !lnk_eop_i |=> !cpu_ready_o); // R5
  AST_NAK_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&full_i) |-> lnk_nak_o); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_ovf_o |=> lnk_ovf_o); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_count_o <= CNT_W'(DEPTH)); // R7
  AST_SWAP_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_trg_we_i && cpu_trg_bit_i && (&full_i) |=> cpu_ready_o); // R8
endmodule

bind pingpong_rx_fifo pingpong_rx_fifo_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lnk_eop_i     (lnk_eop_i),
  .lnk_nak_o     (lnk_nak_o),
  .lnk_ovf_o     (lnk_ovf_o),
  .cpu_count_o   (cpu_count_o),
  .cpu_ready_o   (cpu_ready_o),
  .cpu_trg_we_i  (cpu_trg_we_i),
  .cpu_trg_bit_i (cpu_trg_bit_i),
  .full_i        (bank_full)
);

// File: tb/tb_pingpong_rx_fifo.sv
module tb_pingpong_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lnk_valid = 0, lnk_eop = 0, cpu_rd = 0, trg_we = 0, trg_bit = 0;
  logic [7:0] lnk_data = '0;
  logic lnk_nak, lnk_ovf, cpu_ready;
  logic [7:0] cpu_data, cpu_count;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_rx_fifo dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lnk_valid_i(lnk_valid), .lnk_data_i(lnk_data), .lnk_eop_i(lnk_eop),
    .lnk_nak_o(lnk_nak), .lnk_ovf_o(lnk_ovf),
    .cpu_rd_i(cpu_rd), .cpu_data_o(cpu_data), .cpu_count_o(cpu_count),
    .cpu_ready_o(cpu_ready), .cpu_trg_we_i(trg_we), .cpu_trg_bit_i(trg_bit)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic send_pkt(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      lnk_valid = 1; lnk_data = 8'(base + i); tick();
    end
    lnk_valid = 0; lnk_eop = 1; tick(); lnk_eop = 0;
  endtask

  task automatic trg(input logic b);
    trg_we = 1; trg_bit = b; tick(); trg_we = 0; trg_bit = 0;
  endtask

  task automatic read_pkt(input int n, input int base, input string what);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (cpu_data !== 8'(base + i)) bad++;
      cpu_rd = 1; tick(); cpu_rd = 0;
    end
    chk(bad, 0, what);
  endtask

  task automatic t_reset();
    chk(cpu_count, 0, "R1 count");
    chk(cpu_ready, 0, "R1 ready");
    chk(lnk_nak, 0, "R1 nak");
    chk(lnk_ovf, 0, "R1 ovf");
  endtask

  task automatic t_single();
    for (int i = 0; i < 5; i++) begin
      lnk_valid = 1; lnk_data = 8'(8'h10 + i); tick();
    end
    lnk_valid = 0;
    chk(cpu_count, 0, "R3 count hidden before commit");
    chk(cpu_ready, 0, "R3 not ready before commit");
    lnk_eop = 1; tick(); lnk_eop = 0;
    chk(cpu_ready, 1, "R2 ready after commit");
    chk(cpu_count, 5, "R2 count");
    read_pkt(5, 8'h10, "R2 data order");
    trg(1'b0);
    chk(cpu_ready, 1, "R4 zero write keeps ready");
    chk(cpu_count, 5, "R4 zero write keeps count");
    trg(1'b1);
    chk(cpu_ready, 0, "R8 ready drops when other empty");
    chk(cpu_count, 0, "R4 count cleared");
  endtask

  task automatic t_idle_release();
    trg(1'b1);
    chk(cpu_ready, 0, "R5 ready");
    chk(lnk_nak, 0, "R5 nak");
    chk(cpu_count, 0, "R5 count");
    send_pkt(3, 8'h40);
    chk(cpu_count, 3, "R5 next packet intact");
    read_pkt(3, 8'h40, "R5 data");
    trg(1'b1);
  endtask

  task automatic t_order_nak();
    send_pkt(4, 8'h50);
    send_pkt(6, 8'h60);
    chk(cpu_count, 4, "R3 count frozen while other fills");
    chk(lnk_nak, 1, "R6 nak when both full");
    lnk_valid = 1; lnk_data = 8'h70; tick();
    lnk_data = 8'h71; tick(); lnk_valid = 0;
    lnk_eop = 1; tick(); lnk_eop = 0;
    chk(cpu_count, 4, "R6 dropped bytes leave count");
    read_pkt(4, 8'h50, "R4 reused buffer reads from byte 0");
    trg(1'b1);
    chk(cpu_ready, 1, "R8 swap keeps ready");
    chk(cpu_count, 6, "R8 second packet count");
    chk(lnk_nak, 0, "R6 nak clears after release");
    read_pkt(6, 8'h60, "R8 commit order data");
    trg(1'b1);
    chk(cpu_ready, 0, "R8 ready low, no dropped packet");
  endtask

  task automatic t_zero_len();
    lnk_eop = 1; tick(); lnk_eop = 0;
    chk(cpu_ready, 1, "R9 zero-length ready");
    chk(cpu_count, 0, "R9 zero-length count");
    trg(1'b1);
    chk(cpu_ready, 0, "R9 released");
  endtask

  task automatic t_overflow();
    chk(lnk_ovf, 0, "R7 ovf clear before");
    send_pkt(DEPTH + 2, 0);
    chk(cpu_count, DEPTH, "R7 count capped");
    chk(lnk_ovf, 1, "R7 ovf set");
    read_pkt(DEPTH, 0, "R7 kept bytes");
    trg(1'b1);
    chk(lnk_ovf, 1, "R7 ovf sticky");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1; tick();
    t_single();
    t_idle_release();
    t_order_nak();
    t_zero_len();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule